// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Reload Timer

This block is a 16-bit down-counter with a reload register. An 8-bit processor bus reaches it through two byte addresses. Address 0x22 holds the low byte and address 0x23 holds the high byte. Each address serves both the reload register and the counter. A full 16-bit value moves in one step when software keeps a fixed byte order. For a write, software sends the low byte first and then the high byte. For a read, software takes the high byte first and then the low byte.

The counter drops by one on each cycle that carries a count tick. When a tick arrives at zero, the counter takes the reload value back and a one-cycle interrupt request goes out. There are two measurement modes. In either of them, a selected edge of an external pulse input also puts the reload value back into the counter. The host can use that to time periods or pulse widths.

Top module: `bytewise_reload_timer`

## Requirements
- R1: Reset is synchronous and active high. After reset the counter and the reload register both hold 0xFFFF and `irq` is low.
- R2: A write to address 0x22 changes only a holding byte. The counter and the reload register keep their values.
- R3: A write to address 0x23 loads {written high byte, held low byte} into both the counter and the reload register on that clock edge.
- R4: While `bus_rd` is high, `bus_rdata` follows the address in the same cycle:
  - Address 0x23 gives the live high byte of the counter. At that edge the live low byte is copied into a read buffer.
  - Address 0x22 gives the read buffer.
  - No read, or any other address, gives 0.
  - Reads never change the count.
- R5: A tick while the counter is nonzero, with no higher-priority event, lowers the counter by exactly one.
- R6: A tick while the counter is 0x0000 reloads the counter from the reload register. `irq` is high for exactly the cycle after that edge. Starting from load value L, k ticks leave L - (k mod (L+1)) and give floor(k/(L+1)) pulses.
- R7: In `meas_mode` 2'b01 or 2'b10, an edge of `ext_pulse` reloads the counter from the reload register on the next clock edge, with no `irq`:
  - With `edge_sel` = 1 the edge is rising; with `edge_sel` = 0 it is falling.
  - An edge is judged against the `ext_pulse` value at the previous clock. That stored value resets to 0.
  - A reload from an edge takes the place of a decrement in the same cycle.
- R8: In `meas_mode` 2'b00 or 2'b11, `ext_pulse` has no effect on the counter.
- R9: A commit write to 0x23 overrides an underflow or an edge reload in the same cycle. The written value is loaded and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick, one decrement per asserted cycle |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 8 | Byte register address (0x22 low, 0x23 high) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| ext_pulse | input | 1 | External pulse input, synchronous to clk |
| edge_sel | input | 1 | 1 selects rising edges, 0 selects falling edges |
| meas_mode | input | 2 | 00/11 plain timer, 01 period, 10 pulse-width |
| irq | output | 1 | Underflow interrupt request, one-cycle pulse |

## Verification
If the holding byte or the read buffer went wrong, it would show on the very next high/low access pair. The assembled 16-bit value would be torn: one byte would match the expected value and the other would not. A fault in the reload register cannot be seen until the next underflow or measurement edge. So the bench drives short load values through many wrap cycles and compares the count and the pulse total with the closed form in R6. A fault in the priority between commit, underflow, edge and decrement shows up one cycle after the event that collides, either as a wrong count or as a stray `irq`.

// File: rtl/brt_pkg.sv
package brt_pkg;

    localparam int BYTE_W_DEF = 8;
    localparam int ADDR_W_DEF = 8;
    localparam logic [ADDR_W_DEF-1:0] LO_ADDR_DEF = 8'h22;
    localparam logic [ADDR_W_DEF-1:0] HI_ADDR_DEF = 8'h23;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'b00,
        MODE_PERIOD   = 2'b01,
        MODE_PULSE    = 2'b10,
        MODE_FREE_ALT = 2'b11
    } meas_mode_e;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'b00,
        OP_LOAD   = 2'b01,
        OP_RELOAD = 2'b10,
        OP_DEC    = 2'b11
    } cnt_op_e;

    typedef struct packed {
        logic lo_wr;
        logic commit;
        logic lo_rd;
        logic hi_rd;
    } bus_dec_t;

    function automatic logic mode_measures(meas_mode_e m);
        return (m == MODE_PERIOD) || (m == MODE_PULSE);
    endfunction

    function automatic cnt_op_e pick_op(logic commit, logic underflow,
                                        logic edge_hit, logic tick);
        if (commit)         return OP_LOAD;
        else if (underflow) return OP_RELOAD;
        else if (edge_hit)  return OP_RELOAD;
        else if (tick)      return OP_DEC;
        else                return OP_HOLD;
    endfunction

endpackage

// File: rtl/brt_edge_detect.sv
module brt_edge_detect
    import brt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_pulse,
    input  logic       edge_sel,
    input  meas_mode_e mode,
    output logic       edge_hit
);
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= ext_pulse;
    end

    always_comb begin
        rise     = ext_pulse & ~prev_q;
        fall     = ~ext_pulse & prev_q;
        edge_hit = mode_measures(mode) & (edge_sel ? rise : fall);
    end
endmodule

// File: rtl/brt_bus_port.sv
module brt_bus_port
    import brt_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] LO_ADDR = LO_ADDR_DEF,
    parameter logic [ADDR_W-1:0] HI_ADDR = HI_ADDR_DEF,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic              commit,
    output logic [CNT_W-1:0]  commit_val,
    output logic [BYTE_W-1:0] wbuf_lo,
    output logic [BYTE_W-1:0] bus_rdata
);
    bus_dec_t          dec;
    logic [BYTE_W-1:0] rbuf_lo;

    always_comb begin
        dec.lo_wr  = bus_wr && (bus_addr == LO_ADDR);
        dec.commit = bus_wr && (bus_addr == HI_ADDR);
        dec.lo_rd  = bus_rd && (bus_addr == LO_ADDR);
        dec.hi_rd  = bus_rd && (bus_addr == HI_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_lo <= '1;
            rbuf_lo <= '1;
        end else begin
            if (dec.lo_wr) wbuf_lo <= bus_wdata;
            if (dec.hi_rd) rbuf_lo <= cnt_val[BYTE_W-1:0];
        end
    end

    always_comb begin
        commit     = dec.commit;
        commit_val = {bus_wdata, wbuf_lo};
        if (dec.hi_rd)      bus_rdata = cnt_val[CNT_W-1:BYTE_W];
        else if (dec.lo_rd) bus_rdata = rbuf_lo;
        else                bus_rdata = '0;
    end
endmodule

// File: rtl/brt_count_core.sv
module brt_count_core
    import brt_pkg::*;
#(
    parameter int CNT_W = 2 * BYTE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_val,
    input  logic             edge_hit,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] latch_q,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic    underflow;
    cnt_op_e op;

    always_comb begin
        underflow = tick_en && (cnt_q == '0);
        op        = pick_op(commit, underflow, edge_hit, tick_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '1;
            latch_q <= '1;
            irq     <= 1'b0;
        end else begin
            irq <= underflow && !commit;
            case (op)
                OP_LOAD: begin
                    cnt_q   <= commit_val;
                    latch_q <= commit_val;
                end
                OP_RELOAD: cnt_q <= latch_q;
                OP_DEC:    cnt_q <= cnt_q - ONE;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/bytewise_reload_timer.sv
module bytewise_reload_timer
    import brt_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] LO_ADDR = LO_ADDR_DEF,
    parameter logic [ADDR_W-1:0] HI_ADDR = HI_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_pulse,
    input  logic              edge_sel,
    input  logic [1:0]        meas_mode,
    output logic              irq
);
    localparam int CNT_W = 2 * BYTE_W;

    logic              commit;
    logic [CNT_W-1:0]  commit_val;
    logic [BYTE_W-1:0] wbuf_lo;
    logic [CNT_W-1:0]  cnt_val;
    logic [CNT_W-1:0]  latch_val;
    logic              edge_hit;
    meas_mode_e        mode;

    assign mode = meas_mode_e'(meas_mode);

    brt_bus_port #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W),
        .LO_ADDR(LO_ADDR),
        .HI_ADDR(HI_ADDR)
    ) u_bus (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_val),
        .commit    (commit),
        .commit_val(commit_val),
        .wbuf_lo   (wbuf_lo),
        .bus_rdata (bus_rdata)
    );

    brt_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .ext_pulse(ext_pulse),
        .edge_sel (edge_sel),
        .mode     (mode),
        .edge_hit (edge_hit)
    );

    brt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .commit    (commit),
        .commit_val(commit_val),
        .edge_hit  (edge_hit),
        .cnt_q     (cnt_val),
        .latch_q   (latch_val),
        .irq       (irq)
    );
endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h22,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h23,
    localparam int CNT_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [1:0]        meas_mode,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  latch_val,
    input logic [BYTE_W-1:0] wbuf_lo
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_lo_write_holds_r2: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == LO_ADDR) |-> $stable(latch_val));

    p_commit_loads_r3: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == HI_ADDR) |->
            (cnt_val == {$past(bus_wdata), $past(wbuf_lo)}) &&
            (latch_val == cnt_val));

    p_decrement_r5: assert property (@(posedge clk) disable iff (rst)
        $past(tick_en && cnt_val != '0 && !bus_wr && (meas_mode == 2'b00 || meas_mode == 2'b11))
            |-> cnt_val == $past(cnt_val) - ONE);

    p_irq_reload_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt_val == latch_val) && $past(tick_en) && ($past(cnt_val) == '0));

    p_ext_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!tick_en && !bus_wr && (meas_mode == 2'b00 || meas_mode == 2'b11))
            |-> $stable(cnt_val));

    p_commit_no_irq_r9: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == HI_ADDR) |-> !irq);
endmodule

bind bytewise_reload_timer brt_checker #(
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .meas_mode(meas_mode),
    .irq      (irq),
    .cnt_val  (cnt_val),
    .latch_val(latch_val),
    .wbuf_lo  (wbuf_lo)
);

// File: tb/bytewise_reload_timer_test.sv
module bytewise_reload_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] LO = 8'h22;
    localparam logic [7:0] HI = 8'h23;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext_pulse = 1'b0;
    logic       edge_sel = 1'b1;
    logic [1:0] meas_mode = 2'b00;
    logic       irq;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytewise_reload_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pulse(ext_pulse), .edge_sel(edge_sel), .meas_mode(meas_mode), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic load16(input logic [15:0] v);
        wr_byte(LO, v[7:0]);
        wr_byte(HI, v[15:8]);
    endtask

    task automatic read16(output logic [15:0] v);
        bus_rd = 1'b1; bus_addr = HI;
        #1 v[15:8] = bus_rdata;
        @(negedge clk);
        bus_addr = LO;
        #1 v[7:0] = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_ticks(input int n, output int pulses);
        pulses = 0;
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        tick_en = 1'b0;
    endtask

    task automatic pulse_step(input logic level);
        ext_pulse = level;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        int          p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq after reset", int'(irq), 0);
        read16(v);
        check("R1 counter after reset", int'(v), 16'hFFFF);
        run_ticks(1, p);
        read16(v);
        check("R1 one tick from reset", int'(v), 16'hFFFE);

        // R4 idle and foreign address read zero
        #1 check("R4 idle rdata", int'(bus_rdata), 0);
        bus_rd = 1'b1; bus_addr = 8'h24;
        #1 check("R4 other address rdata", int'(bus_rdata), 0);
        @(negedge clk); bus_rd = 1'b0;

        // R3 commit sweep over many 16-bit values
        for (int i = 0; i < 256; i++) begin
            logic [15:0] w;
            w = {i[7:0], ~i[7:0] ^ 8'h5A};
            load16(w);
            read16(v);
            check("R3 commit roundtrip", int'(v), int'(w));
        end
        load16(16'h0000); read16(v); check("R3 min value", int'(v), 0);
        load16(16'hFFFF); read16(v); check("R3 max value", int'(v), 16'hFFFF);

        // R2 low write alone holds, then is used by high write
        load16(16'h1234);
        wr_byte(LO, 8'h99);
        read16(v);
        check("R2 low write does not load", int'(v), 16'h1234);
        wr_byte(HI, 8'h56);
        read16(v);
        check("R2 held low byte committed", int'(v), 16'h5699);

        // R4 coherent pair while counting across a byte boundary
        load16(16'h0100);
        tick_en = 1'b1; bus_rd = 1'b1; bus_addr = HI;
        #1 v[15:8] = bus_rdata;
        @(negedge clk);
        bus_addr = LO;
        #1 v[7:0] = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; tick_en = 1'b0;
        check("R4 coherent read pair", int'(v), 16'h0100);
        read16(v);
        check("R4 reads leave count alone", int'(v), 16'h00FE);

        // R5 and R6 near-exhaustive wrap sweep over small reload values
        for (int L = 0; L < 8; L++) begin
            for (int k = 0; k <= 20; k++) begin
                load16(16'(L));
                run_ticks(k, p);
                read16(v);
                check("R5 R6 count after ticks", int'(v), L - (k % (L + 1)));
                check("R6 irq pulse total", p, k / (L + 1));
            end
        end
        load16(16'h0002);
        run_ticks(3, p);
        check("R6 irq high after underflow", int'(irq), 1);
        @(negedge clk);
        check("R6 irq lasts one cycle", int'(irq), 0);

        // R7 period mode, rising edge
        meas_mode = 2'b01; edge_sel = 1'b1;
        load16(16'h1000);
        run_ticks(10, p);
        read16(v);
        check("R7 before edge", int'(v), 16'h0FF6);
        pulse_step(1'b1);
        check("R7 no irq on edge reload", int'(irq), 0);
        read16(v);
        check("R7 rising edge reload", int'(v), 16'h1000);
        run_ticks(3, p);
        pulse_step(1'b0);
        read16(v);
        check("R7 falling ignored when rising chosen", int'(v), 16'h0FFD);
        tick_en = 1'b1;
        pulse_step(1'b1);
        tick_en = 1'b0;
        read16(v);
        check("R7 edge beats decrement", int'(v), 16'h1000);

        // R7 pulse-width mode, falling edge
        meas_mode = 2'b10; edge_sel = 1'b0;
        pulse_step(1'b0);
        run_ticks(4, p);
        pulse_step(1'b1);
        read16(v);
        check("R7 rising ignored when falling chosen", int'(v), 16'h0FFC);
        pulse_step(1'b0);
        read16(v);
        check("R7 falling edge reload", int'(v), 16'h1000);

        // R8 plain modes ignore ext_pulse
        for (int m = 0; m < 4; m += 3) begin
            meas_mode = 2'(m);
            for (int s = 0; s < 2; s++) begin
                edge_sel = s[0];
                load16(16'h0800);
                run_ticks(2, p);
                pulse_step(1'b1);
                pulse_step(1'b0);
                read16(v);
                check("R8 ext ignored in plain mode", int'(v), 16'h07FE);
            end
        end

        // R9 commit beats underflow
        meas_mode = 2'b00;
        load16(16'h0000);
        wr_byte(LO, 8'h34);
        tick_en = 1'b1;
        wr_byte(HI, 8'h12);
        tick_en = 1'b0;
        check("R9 no irq when commit wins", int'(irq), 0);
        read16(v);
        check("R9 commit beats underflow", int'(v), 16'h1234);

        // R9 commit beats edge reload
        meas_mode = 2'b01; edge_sel = 1'b1;
        pulse_step(1'b0);
        wr_byte(LO, 8'hCD);
        ext_pulse = 1'b1;
        wr_byte(HI, 8'hAB);
        read16(v);
        check("R9 commit beats edge", int'(v), 16'hABCD);
        ext_pulse = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule